// File: doc/BRIEF.md
# Cache-Line Instruction Unpacker

This block sits between the instruction cache return path and the decode queue of a multithreaded fetch stage. When a 64-byte line comes back for a thread, the block cuts it into 32-bit instruction slots. It starts at the thread's current PC and emits up to `FETCH_WIDTH` slots in one registered output group. Each slot carries its PC, its instruction word, a global sequence number and a predicted next PC.

A branch predictor outside the block receives each candidate slot's PC and word through a combinational lookup port. It answers with is-control, predicted-taken and target for each slot. The fetch group ends at the line end, at the width limit, at a predicted-taken branch or at a quiesce instruction, whichever comes first. At the same clock edge the thread's stored PC moves to the last predicted next PC.

A translation fault reported with the line does not unpack the line. Instead the block emits one no-op slot that carries the fault code and holds the PC. A quiesce instruction or a fault parks the thread. A resume command releases it and can optionally load a new PC.

Top module: `line_unpacker`

## Requirements
- R1: After reset, and in any cycle after an edge with no accepted line, `out_we` is 0, `out_count` is 0 and `out_valid` is all zeros.
- R2: Slot i of a group has PC equal to the line base (the thread PC with its low 6 bits cleared) plus 4 × (w + i), where w is bits 5:2 of the thread PC, so bits 1:0 of the PC are ignored. Its instruction is line word w + i, and word k occupies `line_data[32k+31:32k]`, with line byte b at bits 8b+7:8b (little-endian).
- R3: A group never passes the end of the line: when 16 − w < FETCH_WIDTH, exactly 16 − w slots are emitted, provided no earlier stop applies.
- R4: A group never holds more than FETCH_WIDTH slots.
- R5: The predicted next PC of a slot is the predictor target when that slot is control and predicted taken, and PC + 4 otherwise. A taken slot is the last slot of its group.
- R6: Every emitted slot takes a sequence number one above the previous emitted slot, across groups and threads, starting at 0 after reset.
- R7: An instruction equal to `QUIESCE_WORD` is emitted and counted, ends the group, and parks the thread. Lines for a parked thread are ignored (count 0) until a resume for that thread.
- R8: After a fault-free group the thread PC becomes the predicted next PC of the group's last slot, so the thread's next line starts there.
- R9: A line with `xlate_fault` set yields exactly one slot: PC = thread PC, instruction `NOP_WORD`, next PC = PC + 4, `out_fault` = 1 and the given fault code. The thread then parks with its PC unchanged.
- R10: `out_we` is 1 exactly when `out_count` is nonzero, and `out_valid` has `out_count` ones, packed from bit 0.
- R11: Lines and resumes for one thread leave the PC and park state of every other thread unchanged.
- R12: A resume clears the park state of its thread and, when `rs_load_pc` is 1, loads `rs_pc`. A line for the same thread in the same cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rs_valid | input | 1 | Resume command for a thread |
| rs_tid | input | TID_W | Thread of the resume |
| rs_load_pc | input | 1 | Resume also loads a new PC |
| rs_pc | input | PC_W | PC loaded by a resume |
| line_valid | input | 1 | A cache line has returned |
| line_tid | input | TID_W | Thread that owns the line |
| line_data | input | 512 | Line bytes, byte b at bits 8b+7:8b |
| xlate_fault | input | 1 | Translation of the line address faulted |
| fault_code | input | FC_W | Fault code that goes with `xlate_fault` |
| lk_pc | output | FETCH_WIDTH*PC_W | Candidate slot PCs to the predictor |
| lk_inst | output | FETCH_WIDTH*32 | Candidate slot words to the predictor |
| bp_ctrl | input | FETCH_WIDTH | Slot is a control instruction |
| bp_taken | input | FETCH_WIDTH | Slot predicted taken |
| bp_target | input | FETCH_WIDTH*PC_W | Predicted target per slot |
| out_we | output | 1 | Write enable to the decode queue |
| out_valid | output | FETCH_WIDTH | Per-slot valid |
| out_count | output | CNT_W | Number of valid slots |
| out_tid | output | TID_W | Thread of the group |
| out_pc | output | FETCH_WIDTH*PC_W | Slot PCs |
| out_inst | output | FETCH_WIDTH*32 | Slot instruction words |
| out_npc | output | FETCH_WIDTH*PC_W | Slot predicted next PCs |
| out_seq | output | FETCH_WIDTH*SEQ_W | Slot sequence numbers |
| out_fault | output | 1 | Group is a single fault-carrying no-op |
| out_fault_code | output | FC_W | Fault code of that slot |

## Verification
The bench uses the defaults: FETCH_WIDTH 4, two threads, 32-bit PCs and 16-bit sequence numbers. A width of 4 against a 16-word line makes both stopping rules reachable: a start at word 0 hits the width limit, and a start at word 13 hits the line end after three slots. Two threads let the bench show that parking one thread leaves the other thread's PC and state alone, while the sequence counter keeps running across both.

// File: rtl/line_unpacker_pkg.sv
package line_unpacker_pkg;
    localparam int LINE_BYTES = 64;
    localparam int INST_BYTES = 4;
    localparam int LINE_WORDS = LINE_BYTES / INST_BYTES;
    localparam int OFF_BITS   = $clog2(LINE_BYTES);
    localparam int WIDX_BITS  = $clog2(LINE_WORDS);

    typedef enum logic [1:0] {
        TS_RUN     = 2'd0,
        TS_QUIESCE = 2'd1,
        TS_TRAP    = 2'd2
    } thr_state_e;
endpackage

// File: rtl/lu_slot_extract.sv
module lu_slot_extract
    import line_unpacker_pkg::*;
#(
    parameter int FETCH_WIDTH = 4,
    parameter int PC_W        = 32
) (
    input  logic [PC_W-1:0]              start_pc,
    input  logic [LINE_BYTES*8-1:0]      line_data,
    output logic [FETCH_WIDTH*PC_W-1:0]  slot_pc,
    output logic [FETCH_WIDTH*32-1:0]    slot_inst,
    output logic [FETCH_WIDTH-1:0]       slot_inrange
);
    localparam int IDX_W = WIDX_BITS + 8;

    logic [PC_W-1:0]      line_base;
    logic [WIDX_BITS-1:0] start_word;

    assign line_base  = {start_pc[PC_W-1:OFF_BITS], {OFF_BITS{1'b0}}};
    assign start_word = start_pc[OFF_BITS-1:2];

    for (genvar i = 0; i < FETCH_WIDTH; i++) begin : g_slot
        logic [IDX_W-1:0] idx;
        assign idx = IDX_W'(start_word) + IDX_W'(i);
        assign slot_inrange[i] = (idx < IDX_W'(LINE_WORDS));
        assign slot_pc[i*PC_W +: PC_W] = line_base + PC_W'({idx, 2'b00});
        assign slot_inst[i*32 +: 32] = slot_inrange[i]
            ? line_data[32*idx[WIDX_BITS-1:0] +: 32] : 32'd0;
    end
endmodule

// File: rtl/lu_group_ctl.sv
module lu_group_ctl #(
    parameter int          FETCH_WIDTH  = 4,
    parameter int          PC_W         = 32,
    parameter logic [31:0] QUIESCE_WORD = 32'h0000_0F0F,
    localparam int         CNT_W        = $clog2(FETCH_WIDTH + 1)
) (
    input  logic [FETCH_WIDTH-1:0]       slot_inrange,
    input  logic [FETCH_WIDTH*PC_W-1:0]  slot_pc,
    input  logic [FETCH_WIDTH*32-1:0]    slot_inst,
    input  logic [FETCH_WIDTH-1:0]       bp_ctrl,
    input  logic [FETCH_WIDTH-1:0]       bp_taken,
    input  logic [FETCH_WIDTH*PC_W-1:0]  bp_target,
    output logic [FETCH_WIDTH-1:0]       grp_valid,
    output logic [FETCH_WIDTH*PC_W-1:0]  grp_npc,
    output logic [CNT_W-1:0]             grp_count,
    output logic [PC_W-1:0]              grp_last_npc,
    output logic                         grp_quiesce
);
    logic [FETCH_WIDTH-1:0] is_quiesce;
    logic [FETCH_WIDTH-1:0] is_taken;

    for (genvar i = 0; i < FETCH_WIDTH; i++) begin : g_pred
        assign is_quiesce[i] = (slot_inst[i*32 +: 32] == QUIESCE_WORD);
        assign is_taken[i]   = bp_ctrl[i] & bp_taken[i];
        assign grp_npc[i*PC_W +: PC_W] = is_taken[i]
            ? bp_target[i*PC_W +: PC_W]
            : slot_pc[i*PC_W +: PC_W] + PC_W'(4);
    end

    always_comb begin
        logic alive;
        alive        = 1'b1;
        grp_valid    = '0;
        grp_count    = '0;
        grp_last_npc = '0;
        grp_quiesce  = 1'b0;
        for (int i = 0; i < FETCH_WIDTH; i++) begin
            grp_valid[i] = alive & slot_inrange[i];
            if (grp_valid[i]) begin
                grp_count    = grp_count + CNT_W'(1);
                grp_last_npc = grp_npc[i*PC_W +: PC_W];
                grp_quiesce  = grp_quiesce | is_quiesce[i];
            end
            alive = grp_valid[i] & ~is_taken[i] & ~is_quiesce[i];
        end
    end
endmodule

// File: rtl/lu_thread_state.sv
module lu_thread_state
    import line_unpacker_pkg::*;
#(
    parameter int  NUM_THREADS = 2,
    parameter int  PC_W        = 32,
    localparam int TID_W       = $clog2(NUM_THREADS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rs_valid,
    input  logic [TID_W-1:0] rs_tid,
    input  logic             rs_load_pc,
    input  logic [PC_W-1:0]  rs_pc,
    input  logic             upd_valid,
    input  logic [TID_W-1:0] upd_tid,
    input  logic [PC_W-1:0]  upd_pc,
    input  thr_state_e       upd_state,
    input  logic [TID_W-1:0] rd_tid,
    output logic [PC_W-1:0]  rd_pc,
    output thr_state_e       rd_state
);
    logic [PC_W-1:0] pc_d [NUM_THREADS];
    logic [PC_W-1:0] pc_q [NUM_THREADS];
    thr_state_e      st_d [NUM_THREADS];
    thr_state_e      st_q [NUM_THREADS];

    assign rd_pc    = pc_q[rd_tid];
    assign rd_state = st_q[rd_tid];

    always_comb begin
        for (int t = 0; t < NUM_THREADS; t++) begin
            pc_d[t] = pc_q[t];
            st_d[t] = st_q[t];
            if (rs_valid && rs_tid == TID_W'(t)) begin
                st_d[t] = TS_RUN;
                if (rs_load_pc) pc_d[t] = rs_pc;
            end else if (upd_valid && upd_tid == TID_W'(t)) begin
                st_d[t] = upd_state;
                pc_d[t] = upd_pc;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int t = 0; t < NUM_THREADS; t++) begin
                pc_q[t] <= '0;
                st_q[t] <= TS_RUN;
            end
        end else begin
            for (int t = 0; t < NUM_THREADS; t++) begin
                pc_q[t] <= pc_d[t];
                st_q[t] <= st_d[t];
            end
        end
    end
endmodule

// File: rtl/line_unpacker.sv
module line_unpacker
    import line_unpacker_pkg::*;
#(
    parameter int          FETCH_WIDTH  = 4,
    parameter int          PC_W         = 32,
    parameter int          SEQ_W        = 16,
    parameter int          NUM_THREADS  = 2,
    parameter int          FC_W         = 4,
    parameter logic [31:0] QUIESCE_WORD = 32'h0000_0F0F,
    parameter logic [31:0] NOP_WORD     = 32'h0000_0013,
    localparam int         TID_W        = $clog2(NUM_THREADS),
    localparam int         CNT_W        = $clog2(FETCH_WIDTH + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          rs_valid,
    input  logic [TID_W-1:0]              rs_tid,
    input  logic                          rs_load_pc,
    input  logic [PC_W-1:0]               rs_pc,
    input  logic                          line_valid,
    input  logic [TID_W-1:0]              line_tid,
    input  logic [LINE_BYTES*8-1:0]       line_data,
    input  logic                          xlate_fault,
    input  logic [FC_W-1:0]               fault_code,
    output logic [FETCH_WIDTH*PC_W-1:0]   lk_pc,
    output logic [FETCH_WIDTH*32-1:0]     lk_inst,
    input  logic [FETCH_WIDTH-1:0]        bp_ctrl,
    input  logic [FETCH_WIDTH-1:0]        bp_taken,
    input  logic [FETCH_WIDTH*PC_W-1:0]   bp_target,
    output logic                          out_we,
    output logic [FETCH_WIDTH-1:0]        out_valid,
    output logic [CNT_W-1:0]              out_count,
    output logic [TID_W-1:0]              out_tid,
    output logic [FETCH_WIDTH*PC_W-1:0]   out_pc,
    output logic [FETCH_WIDTH*32-1:0]     out_inst,
    output logic [FETCH_WIDTH*PC_W-1:0]   out_npc,
    output logic [FETCH_WIDTH*SEQ_W-1:0]  out_seq,
    output logic                          out_fault,
    output logic [FC_W-1:0]               out_fault_code
);
    typedef struct packed {
        logic [FETCH_WIDTH-1:0]       valid;
        logic [CNT_W-1:0]             count;
        logic [TID_W-1:0]             tid;
        logic [FETCH_WIDTH*PC_W-1:0]  pc;
        logic [FETCH_WIDTH*32-1:0]    inst;
        logic [FETCH_WIDTH*PC_W-1:0]  npc;
        logic [FETCH_WIDTH*SEQ_W-1:0] seq;
        logic                         fault;
        logic [FC_W-1:0]              fcode;
        logic [SEQ_W-1:0]             seq_next;
    } unp_state_t;

    unp_state_t r_d, r_q;

    logic [PC_W-1:0]        cur_pc;
    thr_state_e             cur_state;
    logic                   accept;
    logic [FETCH_WIDTH-1:0] slot_inrange;
    logic [FETCH_WIDTH-1:0] grp_valid;
    logic [FETCH_WIDTH*PC_W-1:0] grp_npc;
    logic [CNT_W-1:0]       grp_count;
    logic [PC_W-1:0]        grp_last_npc;
    logic                   grp_quiesce;
    logic                   upd_valid;
    logic [PC_W-1:0]        upd_pc;
    thr_state_e             upd_state;

    lu_thread_state #(.NUM_THREADS(NUM_THREADS), .PC_W(PC_W)) u_thr (
        .clk        (clk),
        .rst_n      (rst_n),
        .rs_valid   (rs_valid),
        .rs_tid     (rs_tid),
        .rs_load_pc (rs_load_pc),
        .rs_pc      (rs_pc),
        .upd_valid  (upd_valid),
        .upd_tid    (line_tid),
        .upd_pc     (upd_pc),
        .upd_state  (upd_state),
        .rd_tid     (line_tid),
        .rd_pc      (cur_pc),
        .rd_state   (cur_state)
    );

    lu_slot_extract #(.FETCH_WIDTH(FETCH_WIDTH), .PC_W(PC_W)) u_ext (
        .start_pc     (cur_pc),
        .line_data    (line_data),
        .slot_pc      (lk_pc),
        .slot_inst    (lk_inst),
        .slot_inrange (slot_inrange)
    );

    lu_group_ctl #(
        .FETCH_WIDTH (FETCH_WIDTH),
        .PC_W        (PC_W),
        .QUIESCE_WORD(QUIESCE_WORD)
    ) u_grp (
        .slot_inrange (slot_inrange),
        .slot_pc      (lk_pc),
        .slot_inst    (lk_inst),
        .bp_ctrl      (bp_ctrl),
        .bp_taken     (bp_taken),
        .bp_target    (bp_target),
        .grp_valid    (grp_valid),
        .grp_npc      (grp_npc),
        .grp_count    (grp_count),
        .grp_last_npc (grp_last_npc),
        .grp_quiesce  (grp_quiesce)
    );

    // A resume to the same thread wins over a line in the same cycle.
    assign accept = line_valid && (cur_state == TS_RUN)
                 && !(rs_valid && rs_tid == line_tid);

    always_comb begin
        upd_valid = accept;
        if (xlate_fault) begin
            upd_pc    = cur_pc;
            upd_state = TS_TRAP;
        end else begin
            upd_pc    = grp_last_npc;
            upd_state = grp_quiesce ? TS_QUIESCE : TS_RUN;
        end
    end

    always_comb begin
        r_d          = r_q;
        r_d.valid    = '0;
        r_d.count    = '0;
        r_d.fault    = 1'b0;
        r_d.fcode    = '0;
        if (accept) begin
            r_d.tid = line_tid;
            for (int i = 0; i < FETCH_WIDTH; i++) begin
                r_d.seq[i*SEQ_W +: SEQ_W] = r_q.seq_next + SEQ_W'(i);
            end
            if (xlate_fault) begin
                r_d.valid                  = FETCH_WIDTH'(1);
                r_d.count                  = CNT_W'(1);
                r_d.fault                  = 1'b1;
                r_d.fcode                  = fault_code;
                r_d.pc                     = '0;
                r_d.inst                   = '0;
                r_d.npc                    = '0;
                r_d.pc[PC_W-1:0]           = cur_pc;
                r_d.inst[31:0]             = NOP_WORD;
                r_d.npc[PC_W-1:0]          = cur_pc + PC_W'(4);
                r_d.seq_next               = r_q.seq_next + SEQ_W'(1);
            end else begin
                r_d.valid    = grp_valid;
                r_d.count    = grp_count;
                r_d.pc       = lk_pc;
                r_d.inst     = lk_inst;
                r_d.npc      = grp_npc;
                r_d.seq_next = r_q.seq_next + SEQ_W'(grp_count);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign out_we         = (r_q.count != '0);
    assign out_valid      = r_q.valid;
    assign out_count      = r_q.count;
    assign out_tid        = r_q.tid;
    assign out_pc         = r_q.pc;
    assign out_inst       = r_q.inst;
    assign out_npc        = r_q.npc;
    assign out_seq        = r_q.seq;
    assign out_fault      = r_q.fault;
    assign out_fault_code = r_q.fcode;
endmodule

// File: rtl/line_unpacker_checker.sv
module line_unpacker_checker #(
    parameter int FETCH_WIDTH = 4,
    parameter int SEQ_W       = 16,
    parameter int CNT_W       = 3
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         line_valid,
    input logic                         out_we,
    input logic [FETCH_WIDTH-1:0]       out_valid,
    input logic [CNT_W-1:0]             out_count,
    input logic [FETCH_WIDTH*SEQ_W-1:0] out_seq,
    input logic                         out_fault
);
    a_r10_we_tracks_count: assert property (@(posedge clk) disable iff (!rst_n)
        out_we == (out_count != '0));

    a_r10_valid_popcount: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(out_valid) == int'(out_count));

    a_r10_valid_from_bit0: assert property (@(posedge clk) disable iff (!rst_n)
        out_we |-> out_valid[0]);

    a_r9_fault_single_slot: assert property (@(posedge clk) disable iff (!rst_n)
        out_fault |-> (out_count == CNT_W'(1)));

    a_r1_idle_without_line: assert property (@(posedge clk) disable iff (!rst_n)
        !line_valid |=> !out_we);

    if (FETCH_WIDTH > 1) begin : g_seq
        a_r6_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
            (out_count >= CNT_W'(2)) |->
            (out_seq[SEQ_W +: SEQ_W] == out_seq[0 +: SEQ_W] + SEQ_W'(1)));
    end
endmodule

bind line_unpacker line_unpacker_checker #(
    .FETCH_WIDTH(FETCH_WIDTH), .SEQ_W(SEQ_W), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .line_valid(line_valid), .out_we(out_we),
    .out_valid(out_valid), .out_count(out_count), .out_seq(out_seq),
    .out_fault(out_fault)
);

// File: tb/line_unpacker_tb_top.sv
module line_unpacker_tb_top;
    localparam int FW    = 4;
    localparam int PCW   = 32;
    localparam int SEQW  = 16;
    localparam int FCW   = 4;
    localparam int CNTW  = 3;
    localparam logic [31:0] QW  = 32'h0000_0F0F;
    localparam logic [31:0] NOP = 32'h0000_0013;

    logic clk = 0, rst_n = 0;
    always #2.5 clk = ~clk;

    logic rs_valid = 0, rs_load_pc = 0, line_valid = 0, xlate_fault = 0;
    logic [0:0] rs_tid = 0, line_tid = 0, out_tid;
    logic [PCW-1:0] rs_pc = 0;
    logic [511:0] line_data = 0;
    logic [FCW-1:0] fault_code = 0, out_fault_code;
    logic [FW*PCW-1:0] lk_pc, bp_target, out_pc, out_npc;
    logic [FW*32-1:0] lk_inst, out_inst;
    logic [FW-1:0] bp_ctrl, bp_taken, out_valid;
    logic out_we, out_fault;
    logic [CNTW-1:0] out_count;
    logic [FW*SEQW-1:0] out_seq;

    logic br_en = 0, br_tk = 0;
    logic [PCW-1:0] br_pc = 0, br_tgt = 0;

    always_comb begin
        for (int i = 0; i < FW; i++) begin
            bp_ctrl[i]  = br_en && (lk_pc[i*PCW +: PCW] == br_pc);
            bp_taken[i] = br_tk;
            bp_target[i*PCW +: PCW] = br_tgt;
        end
    end

    line_unpacker dut_i (
        .clk(clk), .rst_n(rst_n), .rs_valid(rs_valid), .rs_tid(rs_tid),
        .rs_load_pc(rs_load_pc), .rs_pc(rs_pc), .line_valid(line_valid),
        .line_tid(line_tid), .line_data(line_data), .xlate_fault(xlate_fault),
        .fault_code(fault_code), .lk_pc(lk_pc), .lk_inst(lk_inst),
        .bp_ctrl(bp_ctrl), .bp_taken(bp_taken), .bp_target(bp_target),
        .out_we(out_we), .out_valid(out_valid), .out_count(out_count),
        .out_tid(out_tid), .out_pc(out_pc), .out_inst(out_inst),
        .out_npc(out_npc), .out_seq(out_seq), .out_fault(out_fault),
        .out_fault_code(out_fault_code)
    );

    int n_checks = 0, n_fail = 0;
    int exp_seq = 0;

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] word_of(logic [PCW-1:0] base, int k);
        return {base[15:0], 16'(k)};
    endfunction

    function automatic logic [511:0] mk_line(logic [PCW-1:0] base);
        logic [511:0] d;
        for (int k = 0; k < 16; k++) d[32*k +: 32] = word_of(base, k);
        return d;
    endfunction

    task automatic resume(logic tid, logic ld, logic [PCW-1:0] pc);
        @(negedge clk);
        rs_valid = 1; rs_tid = tid; rs_load_pc = ld; rs_pc = pc;
        @(negedge clk);
        rs_valid = 0; rs_load_pc = 0;
    endtask

    // Drives one line; outputs are sampled one negedge later.
    task automatic send(logic tid, logic [511:0] d, logic flt, logic [FCW-1:0] fc);
        @(negedge clk);
        line_valid = 1; line_tid = tid; line_data = d;
        xlate_fault = flt; fault_code = fc;
        @(negedge clk);
        line_valid = 0; xlate_fault = 0;
    endtask

    // Checks a fault-free group of cnt slots starting at pc0.
    task automatic chk_group(string req, int cnt, logic [PCW-1:0] pc0);
        logic [PCW-1:0] base;
        base = {pc0[PCW-1:6], 6'b0};
        chk({req, " count"}, 64'(out_count), 64'(cnt));
        chk({req, " valid"}, 64'(out_valid), 64'((1 << cnt) - 1));
        for (int i = 0; i < cnt; i++) begin
            chk({req, " pc"}, 64'(out_pc[i*PCW +: PCW]), 64'(pc0 + 32'(4 * i)));
            chk({req, " inst"}, 64'(out_inst[i*32 +: 32]),
                64'(word_of(base, int'(pc0[5:2]) + i)));
            chk({req, " R6 seq"}, 64'(out_seq[i*SEQW +: SEQW]),
                64'(16'(exp_seq + i)));
        end
        exp_seq += cnt;
    endtask

    task automatic t_reset;
        chk("R1 reset we", 64'(out_we), 64'd0);
        chk("R1 reset count", 64'(out_count), 64'd0);
        chk("R1 reset valid", 64'(out_valid), 64'd0);
    endtask

    task automatic t_width_and_advance;
        resume(0, 1, 32'h1000);
        send(0, mk_line(32'h1000), 0, 0);
        chk_group("R4 R2", 4, 32'h1000);
        chk("R5 npc seq", 64'(out_npc[3*PCW +: PCW]), 64'h1010);
        chk("R10 we", 64'(out_we), 64'd1);
        chk("R2 tid", 64'(out_tid), 64'd0);
        send(0, mk_line(32'h1000), 0, 0);
        chk_group("R8 next", 4, 32'h1010);
        @(negedge clk);
        chk("R1 idle", 64'(out_we), 64'd0);
    endtask

    task automatic t_line_end;
        resume(0, 1, 32'h1036);
        send(0, mk_line(32'h1000), 0, 0);
        chk_group("R3 R2 lowbits", 3, 32'h1034);
        send(0, mk_line(32'h1040), 0, 0);
        chk_group("R8 new line", 4, 32'h1040);
    endtask

    task automatic t_branch;
        resume(0, 1, 32'h2000);
        br_en = 1; br_pc = 32'h2004; br_tk = 0; br_tgt = 32'h2300;
        send(0, mk_line(32'h2000), 0, 0);
        chk_group("R5 not taken", 4, 32'h2000);
        chk("R5 nt npc", 64'(out_npc[1*PCW +: PCW]), 64'h2008);
        resume(0, 1, 32'h2000);
        br_tk = 1;
        send(0, mk_line(32'h2000), 0, 0);
        chk_group("R5 taken", 2, 32'h2000);
        chk("R5 taken npc", 64'(out_npc[1*PCW +: PCW]), 64'h2300);
        br_en = 0;
        send(0, mk_line(32'h2300), 0, 0);
        chk_group("R8 target", 4, 32'h2300);
    endtask

    task automatic t_quiesce;
        logic [511:0] d;
        resume(0, 1, 32'h3000);
        d = mk_line(32'h3000);
        d[32 +: 32] = QW;
        send(0, d, 0, 0);
        chk("R7 count", 64'(out_count), 64'd2);
        chk("R7 inst", 64'(out_inst[32 +: 32]), 64'(QW));
        chk("R7 seq", 64'(out_seq[SEQW +: SEQW]), 64'(16'(exp_seq + 1)));
        exp_seq += 2;
        send(0, mk_line(32'h3000), 0, 0);
        chk("R7 parked", 64'(out_count), 64'd0);
        chk("R7 parked we", 64'(out_we), 64'd0);
    endtask

    task automatic t_fault_other_thread;
        resume(1, 1, 32'h4008);
        send(1, mk_line(32'h4000), 1, 4'd5);
        chk("R9 count", 64'(out_count), 64'd1);
        chk("R9 valid", 64'(out_valid), 64'd1);
        chk("R9 pc", 64'(out_pc[0 +: PCW]), 64'h4008);
        chk("R9 inst", 64'(out_inst[0 +: 32]), 64'(NOP));
        chk("R9 npc", 64'(out_npc[0 +: PCW]), 64'h400C);
        chk("R9 fault", 64'(out_fault), 64'd1);
        chk("R9 code", 64'(out_fault_code), 64'd5);
        chk("R9 R6 seq", 64'(out_seq[0 +: SEQW]), 64'(16'(exp_seq)));
        chk("R9 tid", 64'(out_tid), 64'd1);
        exp_seq += 1;
        send(1, mk_line(32'h4000), 0, 0);
        chk("R9 parked", 64'(out_count), 64'd0);
        // Thread 0 still parked by quiesce: R11
        send(0, mk_line(32'h3000), 0, 0);
        chk("R11 t0 still parked", 64'(out_count), 64'd0);
        resume(1, 0, 32'hDEAD);
        send(1, mk_line(32'h4000), 0, 0);
        chk_group("R9 pc held", 4, 32'h4008);
        chk("R9 fault clear", 64'(out_fault), 64'd0);
        resume(0, 0, 32'hBEEF);
        send(0, mk_line(32'h3000), 0, 0);
        chk_group("R7 R12 resume keeps pc R11", 4, 32'h3008);
    endtask

    task automatic t_collision;
        @(negedge clk);
        rs_valid = 1; rs_tid = 0; rs_load_pc = 1; rs_pc = 32'h5000;
        line_valid = 1; line_tid = 0; line_data = mk_line(32'h3000);
        @(negedge clk);
        rs_valid = 0; rs_load_pc = 0; line_valid = 0;
        chk("R12 line dropped", 64'(out_count), 64'd0);
        send(0, mk_line(32'h5000), 0, 0);
        chk_group("R12 loaded pc", 4, 32'h5000);
    endtask

    initial begin
        #1000000;
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_width_and_advance();
        t_line_end();
        t_branch();
        t_quiesce();
        t_fault_other_thread();
        t_collision();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule